// File: doc/BRIEF.md
# Forced Boot-Mode Reset Selector

This block chooses, each time the core leaves reset, where execution begins: at the base of the boot ROM or at the reset entry of the application flash. A high-voltage detect flag from one dedicated pin requests the choice. Its analog comparator is outside the block, so the flag arrives here as a clean digital level. The request counts only if the flag is already high during reset and stays high for three instruction cycles after reset is released. If the request does not qualify, a programmed flash-execute option bit decides as on any ordinary reset. Once made, the choice is held until the next reset.

While the high-voltage flag is present, the block takes over a companion pin. It drives an internal load clock onto that pin so that boot firmware running a serial slave routine can use it as a shift clock. The dedicated pin's digital read value is forced to 1 for as long as the flag is high. All pins are plain control levels. No data flows through the block, so no valid/ready handshake is involved.

Instruction cycles are marked by a one-clock strobe, `instr_tick_i`. The core is expected to stay halted until `decided_o` rises.

Top module: `fbs_boot_select`

## Requirements
- R1: While `rst_n` is low, or at the first clock edge after `core_rst_i` is sampled high, `decided_o`, `boot_sel_o` and `forced_o` are 0. They stay 0 for as long as `core_rst_i` is held.
- R2: Suppose `hv_det_i` is high at the last edge where `core_rst_i` is sampled high, and stays high through the third `instr_tick_i` strobe sampled after release. Then, after that edge, `decided_o`=1, `forced_o`=1, `boot_sel_o`=1 and `start_addr_o`=BOOT_ENTRY.
- R3: If `hv_det_i` was high at the end of reset but is sampled low before the third strobe, the normal decision (R5) is made at the edge that sees it low. If it is already low at the first edge after release, the normal decision is made at the second edge.
- R4: If `hv_det_i` was low at the last reset edge, the normal decision is made at the first edge after release.
- R5: The normal decision has `forced_o`=0 and `boot_sel_o` equal to the inverse of `flash_exec_opt_i`. With the option at 1, `start_addr_o`=FLASH_ENTRY; with it at 0, `start_addr_o`=BOOT_ENTRY. The option is sampled at the deciding edge.
- R6: Once `decided_o` is 1, changes on `flash_exec_opt_i`, `hv_det_i` and `instr_tick_i` leave `decided_o`, `boot_sel_o`, `forced_o` and `start_addr_o` unchanged until `core_rst_i` is asserted again.
- R7: A rise of `hv_det_i` after reset release never gives `forced_o`=1.
- R8: After any edge that samples `hv_det_i` high, `comp_oe_o`=1 and `comp_do_o` follows `load_clk_i`.
- R9: After any edge that samples `hv_det_i` low, `comp_oe_o`=`norm_oe_i` and `comp_do_o`=`norm_do_i`, so the pin returns to normal within one cycle.
- R10: `sense_o` is 1 whenever `hv_det_i` is 1, and otherwise equals `pin_raw_i`, with no clock delay.
- R11: Only clock cycles with `instr_tick_i`=1 count toward the three-cycle window. Clock cycles without the strobe do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| core_rst_i | input | 1 | Core reset request, active high, synchronous |
| hv_det_i | input | 1 | High-voltage present on the dedicated pin |
| instr_tick_i | input | 1 | One-clock strobe per instruction cycle |
| flash_exec_opt_i | input | 1 | Programmed option: 1 = run from flash on reset |
| load_clk_i | input | 1 | Internal load clock to export |
| pin_raw_i | input | 1 | Digital level from the dedicated pin pad |
| norm_oe_i | input | 1 | Companion pin output enable in normal function |
| norm_do_i | input | 1 | Companion pin data in normal function |
| decided_o | output | 1 | Start choice is made and held |
| boot_sel_o | output | 1 | 1 = start from boot ROM, 0 = from flash |
| forced_o | output | 1 | Boot ROM chosen by the high-voltage request |
| start_addr_o | output | AW | First fetch address within the selected memory |
| comp_oe_o | output | 1 | Companion pin output enable |
| comp_do_o | output | 1 | Companion pin output data |
| sense_o | output | 1 | Digital read value of the dedicated pin |

## Verification
The assertions take the high-voltage flag, the option bit and the tick strobe as ordinary synchronous levels. For the companion-pin checks, they rely on a register that only starts comparing one cycle after power-on reset, so that the flag's value during reset is never used. The stimulus changes every input only at falling clock edges, holds each reset request for several cycles with a steady flag, and issues the tick strobe at a fixed period of one to three clocks. This keeps every edge free of races. The sweep covers every flag-drop cycle from release up to beyond the qualifying window.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [1:0] {
    SEL_RST  = 2'd0,
    SEL_QUAL = 2'd1,
    SEL_DONE = 2'd2
  } sel_state_e;

  typedef struct packed {
    logic boot;
    logic forced;
  } sel_choice_t;

endpackage

// File: rtl/fbs_tick_counter.sv
module fbs_tick_counter #(
  parameter int NEED = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic reached_o
);
  localparam int CW = (NEED > 1) ? $clog2(NEED) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign reached_o = !clr_i && tick_i && (cnt_q == CW'(NEED - 1));
endmodule

// File: rtl/fbs_decide_fsm.sv
module fbs_decide_fsm
  import fbs_pkg::*;
#(
  parameter int          NEED        = 3,
  parameter int          AW          = 16,
  parameter logic [AW-1:0] BOOT_ENTRY  = '0,
  parameter logic [AW-1:0] FLASH_ENTRY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_rst_i,
  input  logic          hv_det_i,
  input  logic          instr_tick_i,
  input  logic          flash_exec_opt_i,
  output logic          decided_o,
  output logic          boot_sel_o,
  output logic          forced_o,
  output logic [AW-1:0] start_addr_o
);
  sel_state_e  state_q, state_d;
  sel_choice_t choice_q, choice_d;
  sel_choice_t normal_choice;
  logic        hv_at_rst_q;
  logic        reached;
  logic        in_qual;

  assign in_qual = (state_q == SEL_QUAL);

  fbs_tick_counter #(.NEED(NEED)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (!in_qual),
    .tick_i    (instr_tick_i),
    .reached_o (reached)
  );

  always_comb begin
    normal_choice.boot   = !flash_exec_opt_i;
    normal_choice.forced = 1'b0;
  end

  always_comb begin
    state_d  = state_q;
    choice_d = choice_q;
    unique case (state_q)
      SEL_RST: begin
        if (hv_at_rst_q) begin
          state_d = SEL_QUAL;
        end else begin
          state_d  = SEL_DONE;
          choice_d = normal_choice;
        end
      end
      SEL_QUAL: begin
        if (!hv_det_i) begin
          state_d  = SEL_DONE;
          choice_d = normal_choice;
        end else if (reached) begin
          state_d  = SEL_DONE;
          choice_d = '{boot: 1'b1, forced: 1'b1};
        end
      end
      default: begin
        state_d = SEL_DONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEL_RST;
      choice_q    <= '0;
      hv_at_rst_q <= 1'b0;
    end else if (core_rst_i) begin
      state_q     <= SEL_RST;
      choice_q    <= '0;
      hv_at_rst_q <= hv_det_i;
    end else begin
      state_q     <= state_d;
      choice_q    <= choice_d;
    end
  end

  assign decided_o    = (state_q == SEL_DONE);
  assign boot_sel_o   = choice_q.boot;
  assign forced_o     = choice_q.forced;
  assign start_addr_o = !decided_o ? '0 :
                        (choice_q.boot ? BOOT_ENTRY : FLASH_ENTRY);
endmodule

// File: rtl/fbs_pin_mux.sv
module fbs_pin_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic hv_det_i,
  input  logic load_clk_i,
  input  logic pin_raw_i,
  input  logic norm_oe_i,
  input  logic norm_do_i,
  output logic comp_oe_o,
  output logic comp_do_o,
  output logic sense_o
);
  logic hv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_q <= 1'b0;
    else        hv_q <= hv_det_i;
  end

  assign comp_oe_o = hv_q ? 1'b1 : norm_oe_i;
  assign comp_do_o = hv_q ? load_clk_i : norm_do_i;
  assign sense_o   = hv_det_i | pin_raw_i;
endmodule

// File: rtl/fbs_boot_select.sv
module fbs_boot_select #(
  parameter int            NEED        = 3,
  parameter int            AW          = 16,
  parameter logic [AW-1:0] BOOT_ENTRY  = '0,
  parameter logic [AW-1:0] FLASH_ENTRY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_rst_i,
  input  logic          hv_det_i,
  input  logic          instr_tick_i,
  input  logic          flash_exec_opt_i,
  input  logic          load_clk_i,
  input  logic          pin_raw_i,
  input  logic          norm_oe_i,
  input  logic          norm_do_i,
  output logic          decided_o,
  output logic          boot_sel_o,
  output logic          forced_o,
  output logic [AW-1:0] start_addr_o,
  output logic          comp_oe_o,
  output logic          comp_do_o,
  output logic          sense_o
);
  fbs_decide_fsm #(
    .NEED        (NEED),
    .AW          (AW),
    .BOOT_ENTRY  (BOOT_ENTRY),
    .FLASH_ENTRY (FLASH_ENTRY)
  ) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .core_rst_i       (core_rst_i),
    .hv_det_i         (hv_det_i),
    .instr_tick_i     (instr_tick_i),
    .flash_exec_opt_i (flash_exec_opt_i),
    .decided_o        (decided_o),
    .boot_sel_o       (boot_sel_o),
    .forced_o         (forced_o),
    .start_addr_o     (start_addr_o)
  );

  fbs_pin_mux u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .hv_det_i   (hv_det_i),
    .load_clk_i (load_clk_i),
    .pin_raw_i  (pin_raw_i),
    .norm_oe_i  (norm_oe_i),
    .norm_do_i  (norm_do_i),
    .comp_oe_o  (comp_oe_o),
    .comp_do_o  (comp_do_o),
    .sense_o    (sense_o)
  );
endmodule

// File: rtl/fbs_boot_select_chk.sv
module fbs_boot_select_chk #(
  parameter int            AW          = 16,
  parameter logic [AW-1:0] BOOT_ENTRY  = '0,
  parameter logic [AW-1:0] FLASH_ENTRY = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_rst_i,
  input logic          hv_det_i,
  input logic          load_clk_i,
  input logic          pin_raw_i,
  input logic          norm_oe_i,
  input logic          norm_do_i,
  input logic          decided_o,
  input logic          boot_sel_o,
  input logic          forced_o,
  input logic [AW-1:0] start_addr_o,
  input logic          comp_oe_o,
  input logic          comp_do_o,
  input logic          sense_o
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_i |=> (!decided_o && !forced_o && !boot_sel_o)); // R1

  AST_FORCED_TO_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    forced_o |-> (decided_o && boot_sel_o && start_addr_o == BOOT_ENTRY)); // R2

  AST_FLASH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (decided_o && !boot_sel_o) |-> (start_addr_o == FLASH_ENTRY && !forced_o)); // R5

  AST_CHOICE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (decided_o && !core_rst_i) |=> (decided_o && $stable(boot_sel_o) &&
                                    $stable(forced_o) && $stable(start_addr_o))); // R6

  AST_PIN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(hv_det_i)) |-> (comp_oe_o && comp_do_o == load_clk_i)); // R8

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(hv_det_i)) |-> (comp_oe_o == norm_oe_i && comp_do_o == norm_do_i)); // R9

  always_comb begin
    if (rst_n && hv_det_i) begin
      AST_SENSE_HIGH: assert (sense_o); // R10
    end
  end
endmodule

bind fbs_boot_select fbs_boot_select_chk #(
  .AW          (AW),
  .BOOT_ENTRY  (BOOT_ENTRY),
  .FLASH_ENTRY (FLASH_ENTRY)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_rst_i   (core_rst_i),
  .hv_det_i     (hv_det_i),
  .load_clk_i   (load_clk_i),
  .pin_raw_i    (pin_raw_i),
  .norm_oe_i    (norm_oe_i),
  .norm_do_i    (norm_do_i),
  .decided_o    (decided_o),
  .boot_sel_o   (boot_sel_o),
  .forced_o     (forced_o),
  .start_addr_o (start_addr_o),
  .comp_oe_o    (comp_oe_o),
  .comp_do_o    (comp_do_o),
  .sense_o      (sense_o)
);

// File: tb/fbs_boot_select_bench.sv
module fbs_boot_select_bench;
  localparam int          AW     = 16;
  localparam logic [15:0] BOOT_A = 16'h0000;
  localparam logic [15:0] FLSH_A = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_rst = 1'b1;
  logic hv = 1'b0;
  logic tick = 1'b0;
  logic opt = 1'b1;
  logic lclk = 1'b0;
  logic raw = 1'b0;
  logic noe = 1'b0;
  logic ndo = 1'b0;
  logic decided, boot_sel, forced, oe, dout, sense;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) lclk <= ~lclk;

  fbs_boot_select #(
    .NEED(3), .AW(AW), .BOOT_ENTRY(BOOT_A), .FLASH_ENTRY(FLSH_A)
  ) u_fbs_boot_select (
    .clk(clk), .rst_n(rst_n), .core_rst_i(core_rst), .hv_det_i(hv),
    .instr_tick_i(tick), .flash_exec_opt_i(opt), .load_clk_i(lclk),
    .pin_raw_i(raw), .norm_oe_i(noe), .norm_do_i(ndo),
    .decided_o(decided), .boot_sel_o(boot_sel), .forced_o(forced),
    .start_addr_o(addr), .comp_oe_o(oe), .comp_do_o(dout), .sense_o(sense)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  // One release scenario: tick period p, hv low from edge d onward,
  // option o, hv level hr during reset.
  task automatic run_case(input int p, input int d, input bit o, input bit hr);
    int  t;
    bit  exp_forced;
    bit  exp_boot;
    int  exp_addr;
    @(negedge clk);
    core_rst = 1'b1; hv = hr; tick = 1'b0; opt = o;
    repeat (3) @(negedge clk);
    chk(decided == 1'b0 && forced == 1'b0, "R1 held in reset", decided, 0);
    if (!hr) begin
      t = 0; exp_forced = 1'b0;                // R4, R7
    end else if (3 * p < d) begin
      t = 3 * p; exp_forced = 1'b1;            // R2, R11
    end else if (d == 0) begin
      t = 1; exp_forced = 1'b0;                // R3
    end else begin
      t = d; exp_forced = 1'b0;                // R3
    end
    exp_boot = exp_forced ? 1'b1 : !o;
    exp_addr = exp_boot ? int'(BOOT_A) : int'(FLSH_A);
    for (int k = 0; k <= 3 * p + 12; k++) begin
      core_rst = 1'b0;
      tick = (k > 0) && (k % p == 0);
      hv = (k < d);
      opt = (k > t) ? !o : o;                  // R6 option changes after decision
      @(negedge clk);
      chk(decided == (k >= t), hr ? (exp_forced ? "R2 decide time" : "R3 decide time")
                                  : "R4 decide time", decided, k >= t);
    end
    chk(forced == exp_forced, hr ? "R2 forced flag" : "R7 late hv ignored", forced, exp_forced);
    chk(boot_sel == exp_boot, "R5 boot select", boot_sel, exp_boot);
    chk(int'(addr) == exp_addr, "R5 start address", addr, exp_addr);
    chk(decided == 1'b1, "R6 choice held", decided, 1);
  endtask

  initial begin
    #1;
    chk(decided == 1'b0 && boot_sel == 1'b0, "R1 power-on reset", decided, 0);
    chk(oe == noe, "R9 pin normal in reset", oe, noe);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int p = 1; p <= 3; p++)
      for (int d = 0; d <= 10; d++)
        for (int o = 0; o <= 1; o++)
          for (int h = 0; h <= 1; h++)
            run_case(p, d, o[0], h[0]);

    // Companion pin and sense path, core already decided.
    @(negedge clk);
    hv = 1'b0; raw = 1'b0; noe = 1'b0; ndo = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0 && dout == 1'b1, "R9 pin normal", {oe, dout}, 1);
    chk(sense == 1'b0, "R10 sense follows raw low", sense, 0);
    raw = 1'b1; #1;
    chk(sense == 1'b1, "R10 sense follows raw high", sense, 1);
    raw = 1'b0; hv = 1'b1; #1;
    chk(sense == 1'b1, "R10 sense high under hv", sense, 1);
    chk(oe == 1'b0, "R8 pin not yet taken before edge", oe, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(oe == 1'b1 && dout == lclk, "R8 load clock out", {oe, dout}, {1'b1, lclk});
    end
    hv = 1'b0; noe = 1'b1; ndo = 1'b0; #1;
    chk(oe == 1'b1, "R8 pin held until edge", oe, 1);
    @(negedge clk);
    chk(oe == 1'b1 && dout == 1'b0, "R9 pin released", {oe, dout}, 2);
    chk(decided == 1'b1, "R6 hv after decision", decided, 1);

    // Reset request clears the choice at the next edge.
    core_rst = 1'b1;
    @(negedge clk);
    chk(decided == 1'b0 && forced == 1'b0, "R1 reset clears", decided, 0);
    finish_run();
  end
endmodule